// File: doc/BRIEF.md
# Multiplexer-Based Perfect Hash Tree

This block turns a wide bit window into a short identifier. The identifier is
unique for every member of a fixed, known set of keys. The hash is a binary
tree of nodes. Each node computes one split bit from the window, and that bit
decides which of the node's two subtrees supplies the rest of the identifier.
An identifier is therefore the sequence of split bits met along one path from
the root down to a leaf. Its width is only as large as needed to number the
key set.

The selection rule of every node is fixed at elaboration time by parameters:
one or two window bit positions per node, and whether the two bits are
XOR-combined. These parameters are found offline for a given key set. The
datapath is pipelined:

- one register stage captures all split bits;
- one further stage follows for each tree level that is merged.

A new window can be accepted on every clock, with a valid strobe travelling
alongside the data. A typical use is to address a memory that holds candidate
patterns, with the window taken from a shift register over a byte stream.

Top module: `phash_tree`

## Requirements
- R1: `out_id` is ceil(log2(N_KEYS)) bits wide, with a minimum of 1 bit. With the default of 8 keys it is 3 bits, and the default key set reaches all 8 codes.
- R2: Every configured key yields an identifier that no other configured key yields. With the default configuration, key k yields identifier k for these keys: 0x00000002, 0x00020108, 0x00005820, 0x10000820, 0x00000008, 0x02320000, 0x00100008, 0x40220000 (k = 0 to 7 in this order).
- R3: Nodes are numbered with the root as node 0. Node i has child 2i+1, taken when its split bit is 0, and child 2i+2, taken when it is 1. The MSB of `out_id` is the root's split bit. Each lower bit is the split bit of the node chosen by the bits above it, and the LSB comes from a leaf node. This holds for any window, including windows outside the key set.
- R4: Node i has two bit positions, A_i in `SEL_A[8i+7:8i]` and B_i in `SEL_B[8i+7:8i]`. Its split bit is `in_win[A_i] ^ in_win[B_i]` when `XOR_EN[i]` is 1, and `in_win[A_i]` otherwise. Bit 0 of `in_win` is its LSB.
- R5: A window is accepted at a rising edge where `in_valid` is high. Its identifier appears with `out_valid` high after ID_W rising edges, counting the accepting edge (3 by default). Windows accepted on consecutive cycles come out on consecutive cycles, in the same order.
- R6: A rising edge with `rst_n` low drives `out_valid` low. It stays low until a window accepted after reset has travelled through the pipeline. Windows in flight at the reset are dropped.
- R7: A cycle with `in_valid` low never produces an `out_valid` pulse, whatever `in_win` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Window on `in_win` is to be hashed this cycle |
| in_win | input | WIN_W | Bit window to hash |
| out_valid | output | 1 | `out_id` holds the identifier of an accepted window |
| out_id | output | ceil(log2(N_KEYS)) | Identifier formed by the split-bit path |

## Verification
The checker assumes four things about its inputs:

- every configured bit position lies inside the window;
- reset is held low on the first clock edge;
- `in_valid` is never unknown once reset is released;
- `in_win` is never unknown once reset is released.

Under these conditions the identifier bits can be recomputed from the input side and compared with `out_id`. The bench keeps within these assumptions: its node positions all stay below 32, it drives known values from time zero, and it changes inputs only on falling edges. Its windows are the eight keys, variants that flip a single XOR-paired bit, and pseudo-random words. It also includes idle stretches and a reset raised while windows are still in the pipeline.

// File: rtl/phash_pkg.sv
// Shared sizing helpers for the perfect hash tree.
// Assumes N_KEYS >= 1; the tree is always full, so unused codes may exist.
package phash_pkg;

    // Width of one bit-position field in the selector parameters.
    localparam int SEL_FW = 8;

    // Identifier width: ceil(log2(n)), at least one bit.
    function automatic int id_width(input int n_keys);
        return (n_keys <= 2) ? 1 : $clog2(n_keys);
    endfunction

    // Number of split nodes in a full tree of id_width levels.
    function automatic int node_count(input int n_keys);
        return (1 << id_width(n_keys)) - 1;
    endfunction

endpackage

// File: rtl/phash_split_bank.sv
// Computes the split bit of every tree node from the window and registers it.
// Each node reads one bit, or the XOR of two bits, at constant positions.
// Assumes every configured position is below WIN_W. Data registers carry no
// reset; qualification is done by the valid pipeline in the top.
module phash_split_bank
    import phash_pkg::*;
#(
    parameter int WIN_W = 32,
    parameter int NODES = 7,
    parameter logic [NODES*SEL_FW-1:0] SEL_A = '0,
    parameter logic [NODES*SEL_FW-1:0] SEL_B = '0,
    parameter logic [NODES-1:0] XOR_EN = '0
)(
    input  logic             clk,
    input  logic [WIN_W-1:0] in_win,
    output logic [NODES-1:0] split_q
);

    logic [NODES-1:0] split_d;
    logic             unused_win;

    // One separating function per node, chosen at elaboration.
    for (genvar n = 0; n < NODES; n++) begin : g_node
        localparam int IA = int'(SEL_A[n*SEL_FW +: SEL_FW]);
        localparam int IB = int'(SEL_B[n*SEL_FW +: SEL_FW]);
        if (XOR_EN[n]) begin : g_xor
            assign split_d[n] = in_win[IA] ^ in_win[IB];
        end else begin : g_one
            assign split_d[n] = in_win[IA];
        end
    end

    // Window bits that no node reads are folded here on purpose.
    assign unused_win = ^in_win;

    // Stage 1: capture all split bits together.
    always_ff @(posedge clk) begin
        split_q <= split_d;
    end

endmodule

// File: rtl/phash_merge_stage.sv
// One pipeline stage of the hash tree: merges tree level LEVEL.
// Each parent at this level takes its own split bit as the new top bit and
// appends the hash of the child that bit selects (bit 0 -> first child).
// Hashes are right-aligned in ID_W-bit slots; slots past the level are zero.
// Split bits of all levels travel along so upper levels stay aligned.
module phash_merge_stage #(
    parameter int ID_W  = 3,
    parameter int LEVEL = 0
)(
    input  logic                 clk,
    input  logic [(1<<ID_W)-2:0] sp_in,
    input  logic [ID_W-1:0]      hh_in  [1<<(ID_W-1)],
    output logic [(1<<ID_W)-2:0] sp_out,
    output logic [ID_W-1:0]      hh_out [1<<(ID_W-1)]
);

    localparam int LEAVES = 1 << (ID_W - 1);
    localparam int NPAR   = 1 << LEVEL;
    localparam int PBASE  = NPAR - 1;
    localparam int CW     = ID_W - 1 - LEVEL;

    logic [ID_W-1:0]   merged [LEAVES];
    logic [LEAVES-1:0] unused_fold;

    // Parent j combines children 2j and 2j+1 of the level below.
    for (genvar j = 0; j < LEAVES; j++) begin : g_par
        if (j < NPAR) begin : g_live
            logic [ID_W-1:0] ch;
            assign ch          = sp_in[PBASE+j] ? hh_in[2*j+1] : hh_in[2*j];
            assign merged[j]   = ID_W'({sp_in[PBASE+j], ch[CW-1:0]});
            assign unused_fold[j] = ^ch;
        end else begin : g_idle
            assign merged[j]   = '0;
            assign unused_fold[j] = (j >= 2*NPAR) ? ^hh_in[j] : 1'b0;
        end
    end

    // Register the merged level and the carried split bits.
    always_ff @(posedge clk) begin
        sp_out <= sp_in;
        hh_out <= merged;
    end

endmodule

// File: rtl/phash_tree.sv
// Pipelined perfect hash tree: window in, path-of-split-bits identifier out.
// Latency is ID_W cycles: one split stage plus one merge per non-leaf level.
// Assumes all configured bit positions lie inside the window. Only the valid
// pipeline is reset (synchronous, active low); data follows unreset.
module phash_tree
    import phash_pkg::*;
#(
    parameter int N_KEYS = 8,
    parameter int WIN_W  = 32,
    parameter logic [node_count(N_KEYS)*SEL_FW-1:0] SEL_A =
        {8'd30, 8'd25, 8'd11, 8'd8, 8'd20, 8'd5, 8'd3},
    parameter logic [node_count(N_KEYS)*SEL_FW-1:0] SEL_B =
        {8'd0, 8'd0, 8'd12, 8'd0, 8'd21, 8'd0, 8'd17},
    parameter logic [node_count(N_KEYS)-1:0] XOR_EN = 7'b0010101
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [WIN_W-1:0]            in_win,
    output logic                        out_valid,
    output logic [id_width(N_KEYS)-1:0] out_id
);

    localparam int ID_W      = id_width(N_KEYS);
    localparam int NODES     = node_count(N_KEYS);
    localparam int LEAVES    = 1 << (ID_W - 1);
    localparam int LEAF_BASE = LEAVES - 1;

    logic [NODES-1:0]  sp_st [ID_W];
    logic [ID_W-1:0]   hh_st [ID_W][LEAVES];
    logic [ID_W-1:0]   v_st;
    logic [LEAVES-1:0] unused_last;
    logic              unused_sp;

    phash_split_bank #(
        .WIN_W (WIN_W),
        .NODES (NODES),
        .SEL_A (SEL_A),
        .SEL_B (SEL_B),
        .XOR_EN(XOR_EN)
    ) u_split (
        .clk    (clk),
        .in_win (in_win),
        .split_q(sp_st[0])
    );

    // Leaf hashes are the leaf split bits themselves.
    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
        assign hh_st[0][j] = ID_W'(sp_st[0][LEAF_BASE+j]);
    end

    // Merge levels bottom-up, one registered stage per level.
    for (genvar k = 1; k < ID_W; k++) begin : g_stage
        phash_merge_stage #(
            .ID_W (ID_W),
            .LEVEL(ID_W - 1 - k)
        ) u_merge (
            .clk   (clk),
            .sp_in (sp_st[k-1]),
            .hh_in (hh_st[k-1]),
            .sp_out(sp_st[k]),
            .hh_out(hh_st[k])
        );
    end

    // Valid strobe travels with the data through every stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_st <= '0;
        end else begin
            v_st[0] <= in_valid;
            for (int i = 1; i < ID_W; i++) begin
                v_st[i] <= v_st[i-1];
            end
        end
    end

    assign out_valid = v_st[ID_W-1];
    assign out_id    = hh_st[ID_W-1][0];

    // Last-stage leftovers with no consumer.
    for (genvar j = 0; j < LEAVES; j++) begin : g_tail
        if (j == 0) begin : g_root
            assign unused_last[j] = 1'b0;
        end else begin : g_rest
            assign unused_last[j] = ^hh_st[ID_W-1][j];
        end
    end
    assign unused_sp = ^sp_st[ID_W-1];

endmodule

// File: rtl/phash_tree_chk.sv
// Assertion checker for phash_tree, bound to every instance.
// Recomputes the root split bit and the level-1 split bit chosen by it from
// the window, and carries them and the valid strobe through shadow delay
// lines. Assumes configured positions lie inside the window.
module phash_tree_chk
    import phash_pkg::*;
#(
    parameter int WIN_W = 32,
    parameter int ID_W  = 3,
    parameter int NODES = 7,
    parameter logic [NODES*SEL_FW-1:0] SEL_A = '0,
    parameter logic [NODES*SEL_FW-1:0] SEL_B = '0,
    parameter logic [NODES-1:0] XOR_EN = '0
)(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIN_W-1:0] in_win,
    input logic             out_valid,
    input logic [ID_W-1:0]  out_id
);

    logic [2:0]      nb;
    logic            chosen;
    logic [ID_W-1:0] sv;
    logic [ID_W-1:0] sr;
    logic [ID_W-1:0] ss;
    logic            unused_win;

    // Split bits of the root and its two children, from the raw window.
    for (genvar n = 0; n < 3; n++) begin : g_nb
        if (n < NODES) begin : g_on
            localparam int IA = int'(SEL_A[n*SEL_FW +: SEL_FW]);
            localparam int IB = int'(SEL_B[n*SEL_FW +: SEL_FW]);
            assign nb[n] = XOR_EN[n] ? (in_win[IA] ^ in_win[IB]) : in_win[IA];
        end else begin : g_off
            assign nb[n] = 1'b0;
        end
    end
    assign chosen     = nb[0] ? nb[2] : nb[1];
    assign unused_win = ^in_win;

    // Shadow valid delay line, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv <= '0;
        end else begin
            sv[0] <= in_valid;
            for (int i = 1; i < ID_W; i++) sv[i] <= sv[i-1];
        end
    end

    // Shadow delay lines for the expected top identifier bits.
    always_ff @(posedge clk) begin
        sr[0] <= nb[0];
        ss[0] <= chosen;
        for (int i = 1; i < ID_W; i++) begin
            sr[i] <= sr[i-1];
            ss[i] <= ss[i-1];
        end
    end

    // R5: out_valid follows accepted windows exactly ID_W cycles later.
    a_r5_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == sv[ID_W-1]);

    // R6: a reset edge leaves out_valid low.
    a_r6_reset_clear: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R3: identifier MSB is the root split bit of the window.
    a_r3_root_bit: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_id[ID_W-1] == sr[ID_W-1]);

    // R5: a valid identifier is never unknown.
    a_r5_known_id: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_id));

    if (ID_W >= 2) begin : g_lvl1
        // R3: second bit is the split of the child picked by the root bit.
        a_r3_level1_bit: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> out_id[ID_W-2] == ss[ID_W-1]);
    end

endmodule

bind phash_tree phash_tree_chk #(
    .WIN_W (WIN_W),
    .ID_W  (ID_W),
    .NODES (NODES),
    .SEL_A (SEL_A),
    .SEL_B (SEL_B),
    .XOR_EN(XOR_EN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_win   (in_win),
    .out_valid(out_valid),
    .out_id   (out_id)
);

// File: tb/tb_phash_tree.sv
// Directed bench for phash_tree: one task per scenario, each self-checking.
module tb_phash_tree;

    localparam int CLK_PERIOD = 10;
    localparam int WIN  = 32;
    localparam int KEYS = 8;
    localparam int IDW  = 3;
    localparam logic [55:0] TB_SEL_A = {8'd30, 8'd25, 8'd11, 8'd8, 8'd20, 8'd5, 8'd3};
    localparam logic [55:0] TB_SEL_B = {8'd0, 8'd0, 8'd12, 8'd0, 8'd21, 8'd0, 8'd17};
    localparam logic [6:0]  TB_XOR   = 7'b0010101;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [WIN-1:0] in_win = '0;
    logic           out_valid;
    logic [IDW-1:0] out_id;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] key_set [KEYS] = '{32'h00000002, 32'h00020108, 32'h00005820,
                                    32'h10000820, 32'h00000008, 32'h02320000,
                                    32'h00100008, 32'h40220000};
    int na [7] = '{3, 5, 20, 8, 11, 25, 30};
    int nbp[7] = '{17, 0, 21, 0, 12, 0, 0};
    bit nx [7] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

    logic           seq_v  [64];
    logic [WIN-1:0] seq_w  [64];
    int             got_id [64];

    phash_tree #(
        .N_KEYS(KEYS),
        .WIN_W (WIN),
        .SEL_A (TB_SEL_A),
        .SEL_B (TB_SEL_B),
        .XOR_EN(TB_XOR)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_win   (in_win),
        .out_valid(out_valid),
        .out_id   (out_id)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // R4: split bit of node n for window w.
    function automatic logic split_of(input int n, input logic [WIN-1:0] w);
        return nx[n] ? (w[na[n]] ^ w[nbp[n]]) : w[na[n]];
    endfunction

    // R3: walk from the root, appending split bits, child 2i+1+h.
    function automatic int model_id(input logic [WIN-1:0] w);
        int node = 0;
        int id = 0;
        for (int l = 0; l < IDW; l++) begin
            logic h;
            h = split_of(node, w);
            id = id * 2 + int'(h);
            node = 2 * node + 1 + int'(h);
        end
        return id;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive seq_v/seq_w for len cycles, checking outputs IDW cycles later.
    task automatic run_seq(input string req, input int len);
        for (int c = 0; c < len + IDW; c++) begin
            @(negedge clk);
            if (c >= IDW) begin
                check(req, "out_valid", int'(out_valid), int'(seq_v[c-IDW]));
                if (seq_v[c-IDW]) begin
                    check(req, "out_id", int'(out_id), model_id(seq_w[c-IDW]));
                    got_id[c-IDW] = int'(out_id);
                end
            end
            if (c < len) begin
                in_valid = seq_v[c];
                in_win   = seq_w[c];
            end else begin
                in_valid = 1'b0;
                in_win   = '0;
            end
        end
    endtask

    // R1, R6: reset state and identifier width.
    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_win = key_set[3];
        repeat (3) @(negedge clk);
        check("R6", "out_valid in reset", int'(out_valid), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R6", "out_valid after reset", int'(out_valid), 0);
        check("R1", "id width", $bits(out_id), IDW);
    endtask

    // R2, R1: each key alone, separated by idle cycles.
    task automatic t_keys_single();
        for (int k = 0; k < KEYS; k++) begin
            seq_v[0] = 1'b1; seq_w[0] = key_set[k];
            seq_v[1] = 1'b0; seq_w[1] = key_set[k];
            run_seq("R2", 2);
            check("R2", "key id", got_id[0], k);
        end
    endtask

    // R5, R2: keys back to back in scrambled order; pairwise distinct.
    task automatic t_keys_stream();
        int order [KEYS] = '{5, 2, 7, 0, 3, 6, 1, 4};
        for (int i = 0; i < KEYS; i++) begin
            seq_v[i] = 1'b1;
            seq_w[i] = key_set[order[i]];
        end
        run_seq("R5", KEYS);
        for (int i = 0; i < KEYS; i++) begin
            check("R2", "stream key id", got_id[i], order[i]);
            for (int j = i + 1; j < KEYS; j++) begin
                check("R2", "distinct ids", int'(got_id[i] != got_id[j]), 1);
            end
        end
    endtask

    // R4: flipping one XOR-paired bit changes the path as the rule says.
    task automatic t_xor_rule();
        seq_v[0] = 1'b1; seq_w[0] = 32'h00020002;  // key0 + bit17: root 1
        seq_v[1] = 1'b1; seq_w[1] = 32'h0002000A;  // bits 3 and 17 cancel
        seq_v[2] = 1'b1; seq_w[2] = 32'h00300008;  // key6 + bit21: node2 0
        run_seq("R4", 3);
        check("R4", "root xor set", got_id[0], 4);
        check("R4", "root xor cancel", got_id[1], 0);
        check("R4", "node2 xor cancel", got_id[2], 4);
    endtask

    // R3: arbitrary windows, some gaps, against the path model.
    task automatic t_arbitrary();
        logic [31:0] s = 32'h1234_5679;
        for (int i = 0; i < 40; i++) begin
            s = s ^ (s << 13);
            s = s ^ (s >> 17);
            s = s ^ (s << 5);
            seq_v[i] = (i % 7) != 3;
            seq_w[i] = s;
        end
        run_seq("R3", 40);
    endtask

    // R7: windows presented with in_valid low give no out_valid.
    task automatic t_idle();
        for (int i = 0; i < 8; i++) begin
            seq_v[i] = 1'b0;
            seq_w[i] = key_set[i];
        end
        run_seq("R7", 8);
    endtask

    // R6: reset while windows are in flight drops them.
    task automatic t_midreset();
        @(negedge clk);
        in_valid = 1'b1; in_win = key_set[1];
        @(negedge clk);
        in_win = key_set[2];
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check("R6", "out_valid after mid reset", int'(out_valid), 0);
        rst_n = 1'b1;
        for (int i = 0; i < IDW + 1; i++) begin
            @(negedge clk);
            check("R6", "in-flight dropped", int'(out_valid), 0);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        t_reset();
        t_keys_single();
        t_keys_stream();
        t_xor_rule();
        t_arbitrary();
        t_idle();
        t_midreset();
        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule